// File: doc/BRIEF.md
# Three-Stage Fetch and Link Unit

This block owns the program counter and the instruction-fetch sequencing of a 32-bit core built as a fetch, decode and execute pipeline. Each cycle it presents a fetch address to instruction memory and takes the returned word in the same cycle. It carries every instruction, together with its address, through decode into execute. It then shows the execute stage the PC value that the pipeline makes visible. Because fetch is always two words ahead of execute, that value is the executing instruction's address plus 8.

The execute stage reports three kinds of control transfer through decoded strobes. The first is a PC-relative branch. Its target is the plus-8 PC plus a signed 24-bit word offset, scaled by four. The second is the same branch with link. Here the block also emits a link-register write whose value is the address of the instruction after the branch, with its two low bits forced to zero. The third is a direct write of a register value into the PC, which restarts fetch at exactly that value. Any transfer discards the two younger instructions already in flight, and fetch resumes at the target. No status information is saved with the return address.

Top module: `fetch_link_unit`

## Requirements
- R1: While reset is asserted and right after it is released, the fetch address is 0 and `exValid` is 0. With no transfers, the word fetched at address 0 first reaches execute in the third cycle after release.
- R2: With no transfer, the fetch address grows by 4 each cycle. The instruction in execute is the word fetched two cycles earlier, and `exAddr` is its fetch address.
- R3: Whenever `exValid` is 1, `exPc` equals `exAddr + 8`.
- R4: A taken branch (`brTake`=1, `pcWrite`=0, `exValid`=1) makes the next fetch address `exAddr + 8 + (sign-extended brOffset << 2)`, modulo 2^32.
- R5: After any transfer, `exValid` is 0 for the next two cycles. In the third cycle the instruction fetched at the target is in execute.
- R6: A taken branch with `brLink`=1 and `pcWrite`=0 raises `lrWe` in the same cycle. `lrData` is `exAddr + 4` with bits [1:0] cleared.
- R7: `lrWe` stays 0 for a branch without link, for a PC write, and whenever `exValid` is 0. While `exValid` is 0, `brTake`, `brLink` and `pcWrite` are ignored and fetch goes on sequentially.
- R8: `pcWrite`=1 with `exValid`=1 makes the next fetch address exactly `pcWriteData`, with no offset and no alignment. It takes priority over `brTake` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| imemAddr | output | 32 | Instruction fetch address |
| imemData | input | 32 | Word read at `imemAddr`, same cycle |
| brTake | input | 1 | Execute stage: branch taken |
| brLink | input | 1 | Execute stage: branch also writes the link register |
| brOffset | input | 24 | Signed word offset of the branch |
| pcWrite | input | 1 | Execute stage: write a register value into the PC |
| pcWriteData | input | 32 | Value written into the PC |
| exValid | output | 1 | Execute stage holds a real instruction |
| exInstr | output | 32 | Instruction in execute |
| exAddr | output | 32 | Address of the instruction in execute |
| exPc | output | 32 | PC value seen by execute (`exAddr + 8`) |
| lrWe | output | 1 | Link-register write enable |
| lrData | output | 32 | Return address for the link register |

## Verification
The bench aims at transfers issued back to back and at transfer strobes raised while execute holds a bubble. A design that flushed only one stage, or that acted on strobes during a bubble, would execute a discarded instruction or jump twice. Offsets at both ends of the 24-bit range are used. A design that left out sign extension or the scaling by four would jump to the wrong address. Unaligned PC writes, followed by link branches, show whether the PC write is applied exactly and whether the link value has its low bits cleared. A design that saved the plus-8 value instead of the plus-4 value would return one instruction too far.

// File: rtl/flu_pkg.sv
package flu_pkg;
  typedef struct packed {
    logic redirect;    // execute-stage transfer: refill the pipeline
    logic selPcWrite;  // target comes from the PC-write data
    logic linkWrite;   // emit return address to the link register
  } fluStrobes_t;
endpackage

// File: rtl/flu_ctrl.sv
module flu_ctrl
  import flu_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        exValid,
  input  logic        brTake,
  input  logic        brLink,
  input  logic        pcWrite,
  output fluStrobes_t strobes
);
  logic transferReq;

  always_comb begin
    transferReq        = brTake | pcWrite;
    strobes.redirect   = exValid & transferReq;
    strobes.selPcWrite = pcWrite;
    strobes.linkWrite  = exValid & brTake & brLink & ~pcWrite;
  end

  // R7: a link write always comes with a refill of the pipeline
  assert_link_redirect_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.linkWrite |-> strobes.redirect);
endmodule

// File: rtl/flu_datapath.sv
module flu_datapath
  import flu_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int INSTR_W    = 32,
  parameter int OFFSET_W   = 24,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0
)(
  input  logic               clk,
  input  logic               rstN,
  input  fluStrobes_t        strobes,
  input  logic [OFFSET_W-1:0] brOffset,
  input  logic [ADDR_W-1:0]  pcWriteData,
  input  logic [INSTR_W-1:0] imemData,
  output logic [ADDR_W-1:0]  imemAddr,
  output logic               exValid,
  output logic [INSTR_W-1:0] exInstr,
  output logic [ADDR_W-1:0]  exAddr,
  output logic [ADDR_W-1:0]  exPc,
  output logic [ADDR_W-1:0]  lrData
);
  localparam int STEP_BYTES = INSTR_W / 8;
  localparam int EXT_W      = ADDR_W - OFFSET_W - 2;
  localparam logic [ADDR_W-1:0] STEP  = ADDR_W'(STEP_BYTES);
  localparam logic [ADDR_W-1:0] AHEAD = ADDR_W'(2 * STEP_BYTES);

  logic [ADDR_W-1:0]  fetchPc, nextPc, branchTarget, offsetBytes, linkSum;
  logic               decValid;
  logic [INSTR_W-1:0] decInstr;
  logic [ADDR_W-1:0]  decAddr;

  // fetchPc sits two words ahead of execute, so it is the visible PC
  assign imemAddr     = fetchPc;
  assign exPc         = fetchPc;
  assign offsetBytes  = {{EXT_W{brOffset[OFFSET_W-1]}}, brOffset, 2'b00};
  assign branchTarget = fetchPc + offsetBytes;
  assign linkSum      = exAddr + STEP;
  assign lrData       = {linkSum[ADDR_W-1:2], 2'b00};

  always_comb begin
    if (strobes.redirect)
      nextPc = strobes.selPcWrite ? pcWriteData : branchTarget;
    else
      nextPc = fetchPc + STEP;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fetchPc  <= RESET_ADDR;
      decValid <= 1'b0;
      decInstr <= '0;
      decAddr  <= '0;
      exValid  <= 1'b0;
      exInstr  <= '0;
      exAddr   <= '0;
    end else begin
      fetchPc <= nextPc;
      if (strobes.redirect) begin
        decValid <= 1'b0;
        exValid  <= 1'b0;
      end else begin
        exValid  <= decValid;
        exInstr  <= decInstr;
        exAddr   <= decAddr;
        decValid <= 1'b1;
        decInstr <= imemData;
        decAddr  <= fetchPc;
      end
    end
  end

  // R3: fetch counter and execute address stay exactly two words apart
  assert_plus8_R3: assert property (@(posedge clk) disable iff (!rstN)
    exValid |-> (exPc == exAddr + AHEAD));

  // R4: branch lands at the plus-8 PC plus the scaled offset
  assert_branch_target_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.redirect && !strobes.selPcWrite) |=>
      (imemAddr == $past(exAddr) + AHEAD + $past(offsetBytes)));

  // R5: both younger stages are empty after a transfer
  assert_flush_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.redirect |=> (!exValid && !decValid));

  // R5: a refilled decode stage keeps execute empty one more cycle
  assert_refill_R5: assert property (@(posedge clk) disable iff (!rstN)
    (rstN && !decValid && !strobes.redirect) |=> !exValid);

  // R6: the return address is the visible PC backed off by one word
  assert_link_value_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.linkWrite |-> (lrData == ((exPc - STEP) & ~ADDR_W'(3))));

  // R7: a bubble in execute leaves fetch sequential
  assert_bubble_seq_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rstN && !exValid) |=> (imemAddr == $past(imemAddr) + STEP));

  // R8: a PC write is taken verbatim
  assert_pc_write_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.redirect && strobes.selPcWrite) |=> (imemAddr == $past(pcWriteData)));
endmodule

// File: rtl/fetch_link_unit.sv
module fetch_link_unit
  import flu_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int INSTR_W  = 32,
  parameter int OFFSET_W = 24
)(
  input  logic                clk,
  input  logic                rstN,
  output logic [ADDR_W-1:0]   imemAddr,
  input  logic [INSTR_W-1:0]  imemData,
  input  logic                brTake,
  input  logic                brLink,
  input  logic [OFFSET_W-1:0] brOffset,
  input  logic                pcWrite,
  input  logic [ADDR_W-1:0]   pcWriteData,
  output logic                exValid,
  output logic [INSTR_W-1:0]  exInstr,
  output logic [ADDR_W-1:0]   exAddr,
  output logic [ADDR_W-1:0]   exPc,
  output logic                lrWe,
  output logic [ADDR_W-1:0]   lrData
);
  fluStrobes_t strobes;

  flu_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .exValid (exValid),
    .brTake  (brTake),
    .brLink  (brLink),
    .pcWrite (pcWrite),
    .strobes (strobes)
  );

  flu_datapath #(
    .ADDR_W   (ADDR_W),
    .INSTR_W  (INSTR_W),
    .OFFSET_W (OFFSET_W)
  ) u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .brOffset    (brOffset),
    .pcWriteData (pcWriteData),
    .imemData    (imemData),
    .imemAddr    (imemAddr),
    .exValid     (exValid),
    .exInstr     (exInstr),
    .exAddr      (exAddr),
    .exPc        (exPc),
    .lrData      (lrData)
  );

  assign lrWe = strobes.linkWrite;
endmodule

// File: tb/fetch_link_unit_bench.sv
`timescale 1ns/1ps
module fetch_link_unit_bench;
  localparam int CYCLES = 3000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] imemAddr, imemData, pcWriteData, exInstr, exAddr, exPc, lrData;
  logic        brTake = 0, brLink = 0, pcWrite = 0;
  logic [23:0] brOffset = '0;
  logic        exValid, lrWe;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  function automatic logic [31:0] memWord(logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h5A5A0000;
  endfunction

  assign imemData = memWord(imemAddr);

  fetch_link_unit u_fetch_link_unit (
    .clk(clk), .rstN(rstN), .imemAddr(imemAddr), .imemData(imemData),
    .brTake(brTake), .brLink(brLink), .brOffset(brOffset),
    .pcWrite(pcWrite), .pcWriteData(pcWriteData),
    .exValid(exValid), .exInstr(exInstr), .exAddr(exAddr), .exPc(exPc),
    .lrWe(lrWe), .lrData(lrData)
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // behavioural reference: fetch counter plus an in-flight list of {valid, addr}
  logic [31:0] mFetch;
  logic        mDecV, mExV;
  logic [31:0] mDecA, mExA;
  string       lastKind;
  logic [31:0] rnd = 32'h1234_5678;

  initial begin
    pcWriteData = '0;
    mFetch = 0; mDecV = 0; mExV = 0; mDecA = 0; mExA = 0;
    lastKind = "R1";
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "imemAddr in reset", imemAddr, 32'h0);
    chk("R1", "exValid in reset", {31'b0, exValid}, 32'h0);
    @(negedge clk);
    rstN = 1'b1;
    for (int i = 0; i < CYCLES; i++) begin
      logic        redirect, expLrWe;
      logic [31:0] expLr, target, sext;
      // state outputs
      chk(lastKind, "imemAddr", imemAddr, mFetch);
      chk(i < 4 ? "R1" : "R5", "exValid", {31'b0, exValid}, {31'b0, mExV});
      if (mExV) begin
        chk("R2", "exAddr", exAddr, mExA);
        chk("R2", "exInstr", exInstr, memWord(mExA));
        chk("R3", "exPc", exPc, mExA + 32'd8);
      end
      // new stimulus
      rnd ^= rnd << 13; rnd ^= rnd >> 17; rnd ^= rnd << 5;
      if (i < 10) begin
        brTake = 0; brLink = 0; pcWrite = 0;
      end else begin
        brTake  = (rnd[1:0] == 2'b00);
        pcWrite = (rnd[4:2] == 3'b000);
        brLink  = rnd[5];
      end
      case (rnd[9:8])
        2'd0: brOffset = 24'h800000;
        2'd1: brOffset = 24'h7FFFFF;
        default: brOffset = {rnd[31:28] == 4'h0 ? 8'hFF : 8'h00, rnd[31:16]};
      endcase
      pcWriteData = rnd[6] ? {rnd[30:10], rnd[20:12], 2'b00} : {rnd[25:0], rnd[31:26]};
      #1;
      redirect = mExV && (brTake || pcWrite);
      expLrWe  = mExV && brTake && brLink && !pcWrite;
      expLr    = (mExA + 32'd4) & ~32'd3;
      chk(expLrWe ? "R6" : "R7", "lrWe", {31'b0, lrWe}, {31'b0, expLrWe});
      if (expLrWe) chk("R6", "lrData", lrData, expLr);
      // advance reference
      if (redirect) begin
        sext = {{6{brOffset[23]}}, brOffset, 2'b00};
        target = pcWrite ? pcWriteData : (mExA + 32'd8 + sext);
        lastKind = pcWrite ? "R8" : "R4";
        mFetch = target; mDecV = 0; mExV = 0;
      end else begin
        lastKind = "R2";
        mExV = mDecV; mExA = mDecA;
        mDecV = 1; mDecA = mFetch;
        mFetch = mFetch + 32'd4;
      end
      @(negedge clk);
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5.0 * (CYCLES + 100));
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule